// File: doc/BRIEF.md
# Per-Core Countdown Tick Timer

This block is a countdown timer private to one processor. Software programs it through a small register window: a control word, a reload value, a read-only live count and a prescaler select. A prescaler slows the bus clock, and the live count drops by one on each slowed tick. When the count runs out, the timer raises an interrupt request that carries the programmed vector number, unless the request is masked. The timer can fire once and stop, or it can reload itself and fire at a fixed period.

The register port is a plain single-cycle bus. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. A read samples its register on the edge where `bus_sel` is high and `bus_wr` is low, and `bus_rdata` holds that value from the next cycle on. The interrupt request leaves the block as a valid/ready stream. Once `irq_valid` rises, it stays high and `irq_vector` stays stable until the edge that sees `irq_ready` high. The consumer can therefore stall a request for as long as it needs, and no request is lost or altered while it waits. If a further expiry occurs while a request is still pending and not yet accepted, it merges into that request.

Top module: `ptt_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000, with the mask set and the vector, mode and busy bits at zero. The reload, live count and prescaler registers read 0, and `irq_valid` is low.
- R2: The block decodes the full 12-bit address: 0x320 is the control word, 0x380 the reload value, 0x390 the live count and 0x3E0 the prescaler select. The control word holds the vector in [7:0], busy in [12], mask in [16] and mode in [17]. All other control bits read 0 and ignore writes, so writing all ones reads back 0x0003_00FF while the timer is idle. Any other address reads 0.
- R3: The prescaler code is {bit3, bit1, bit0} of the prescaler select register. The other bits of that register read 0, so writing all ones reads back 0x0000_000B. Codes 0 through 6 divide by 2, 4, 8, 16, 32, 64 and 128, and code 7 divides by 1.
- R4: A write of N to the reload value loads the live count with N and restarts the prescaler at that edge. With a divide ratio D, expiry happens on the N·D-th edge after the write.
- R5: With mode 0 (one-shot), the timer raises exactly one request, and the live count then stays at 0 until the reload value is written again.
- R6: With mode 1 (periodic), the live count reloads from the reload value on each expiry, and requests follow every N·D edges.
- R7: Writing 0 to the reload value stops the count, and no further request follows.
- R8: With mask 1, an expiry raises no request, but the count still runs down.
- R9: `irq_valid` stays high, with `irq_vector` stable, until it is accepted by `irq_ready`. Busy (bit 12) reads 1 exactly while a request is pending.
- R10: The live count ignores writes, and a read returns the count as it stood before the read edge.
- R11: A write to the prescaler select restarts the prescaler, so the first tick after the write comes a full ratio later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_valid | output | 1 | Interrupt request pending |
| irq_ready | input | 1 | Consumer accepts the request |
| irq_vector | output | 8 | Vector number of the pending request |

## Verification
The assertions assume that `irq_ready` is a clean level sampled at the clock. They also assume that the live count changes only through a reload write, a tick decrement or a periodic reload. The bench drives every input one time unit after a rising edge, so each access lands on exactly one known edge. It lines up expiries against that edge count. Stalls on the request stream are produced only by holding `irq_ready` low across a whole window, and the bench then checks that busy and the vector hold steady.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 3;

  localparam logic [ADDR_W-1:0] OFF_CTL    = 12'h320;
  localparam logic [ADDR_W-1:0] OFF_RELOAD = 12'h380;
  localparam logic [ADDR_W-1:0] OFF_LIVE   = 12'h390;
  localparam logic [ADDR_W-1:0] OFF_DIV    = 12'h3E0;

  localparam int BIT_BUSY = 12;
  localparam int BIT_MASK = 16;
  localparam int BIT_MODE = 17;

  typedef enum logic {MODE_ONCE = 1'b0, MODE_REPEAT = 1'b1} run_mode_e;

  typedef struct packed {
    run_mode_e        mode;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } ctl_t;
endpackage

// File: rtl/ptt_prescale.sv
module ptt_prescale
  import ptt_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int NCODES = 1 << CODE_W;

  logic [PRE_W-1:0] lim_tab [NCODES];
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  for (genvar g = 0; g < NCODES; g++) begin : g_lim
    if (g == NCODES - 1) begin : g_one
      assign lim_tab[g] = '0;
    end else begin : g_pow
      assign lim_tab[g] = PRE_W'((1 << (g + 1)) - 1);
    end
  end

  assign lim  = lim_tab[code];
  assign tick = (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptt_regs.sv
module ptt_regs
  import ptt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] live,
  input  logic              busy,
  output ctl_t              ctl,
  output logic [DATA_W-1:0] reload,
  output logic [CODE_W-1:0] code,
  output logic              ld_reload,
  output logic              ld_div
);
  logic wr_en, rd_en;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en     = bus_sel & bus_wr;
  assign rd_en     = bus_sel & ~bus_wr;
  assign ld_reload = wr_en && (bus_addr == OFF_RELOAD);
  assign ld_div    = wr_en && (bus_addr == OFF_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl.mode <= MODE_ONCE;
      ctl.mask <= 1'b1;
      ctl.vec  <= '0;
      reload   <= '0;
      code     <= '0;
    end else begin
      if (wr_en && (bus_addr == OFF_CTL)) begin
        ctl.mode <= run_mode_e'(bus_wdata[BIT_MODE]);
        ctl.mask <= bus_wdata[BIT_MASK];
        ctl.vec  <= bus_wdata[VEC_W-1:0];
      end
      if (ld_reload) reload <= bus_wdata;
      if (ld_div)    code   <= {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFF_CTL: begin
        rd_mux[VEC_W-1:0] = ctl.vec;
        rd_mux[BIT_BUSY]  = busy;
        rd_mux[BIT_MASK]  = ctl.mask;
        rd_mux[BIT_MODE]  = ctl.mode;
      end
      OFF_RELOAD: rd_mux = reload;
      OFF_LIVE:   rd_mux = live;
      OFF_DIV: begin
        rd_mux[3] = code[2];
        rd_mux[1] = code[1];
        rd_mux[0] = code[0];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ptt_count.sv
module ptt_count
  import ptt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] reload,
  input  run_mode_e         mode,
  input  logic              tick,
  output logic [DATA_W-1:0] live,
  output logic              expire
);
  logic running;

  assign running = (live != '0);
  assign expire  = !load && tick && (live == DATA_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
    end else if (load) begin
      live <= load_val;
    end else if (tick && running) begin
      if (expire) live <= (mode == MODE_REPEAT) ? reload : '0;
      else        live <= live - 1'b1;
    end
  end
endmodule

// File: rtl/ptt_irq.sv
module ptt_irq
  import ptt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             mask,
  input  logic [VEC_W-1:0] vec,
  input  logic             irq_ready,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic stalled, raise;

  assign stalled = irq_valid && !irq_ready;
  assign raise   = expire && !mask && !stalled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else if (raise) begin
      irq_valid  <= 1'b1;
      irq_vector <= vec;
    end else if (irq_valid && irq_ready) begin
      irq_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/ptt_timer.sv
module ptt_timer
  import ptt_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector
);
  ctl_t              ctl;
  logic [DATA_W-1:0] reload, live;
  logic [CODE_W-1:0] code;
  logic              ld_reload, ld_div, tick, expire;

  ptt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .live(live), .busy(irq_valid), .ctl(ctl), .reload(reload),
    .code(code), .ld_reload(ld_reload), .ld_div(ld_div)
  );

  ptt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ld_div | ld_reload),
    .code(code), .tick(tick)
  );

  ptt_count u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld_reload), .load_val(bus_wdata),
    .reload(reload), .mode(ctl.mode), .tick(tick), .live(live),
    .expire(expire)
  );

  ptt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .mask(ctl.mask),
    .vec(ctl.vec), .irq_ready(irq_ready), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );
endmodule

// File: rtl/ptt_timer_chk.sv
module ptt_timer_chk
  import ptt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [DATA_W-1:0] live,
  input logic [DATA_W-1:0] reload,
  input logic              ld_reload,
  input logic              mask
);
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid); // R9
  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> $stable(irq_vector)); // R9
  AST_NO_RAISE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> !$past(mask)); // R8
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) && !ld_reload |=> live == '0); // R7
  AST_LIVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    live <= reload); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_reload |=> (live == $past(live)) || (live == $past(live) - 1'b1)
                   || (live == $past(reload))); // R4
endmodule

bind ptt_timer ptt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .live(live), .reload(reload),
  .ld_reload(ld_reload), .mask(ctl.mask)
);

// File: tb/tb_ptt_timer.sv
module tb_ptt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_valid, irq_ready = 1'b1;
  logic [7:0]  irq_vector;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int        q_cyc[$];
  logic [7:0] q_vec[$];
  string     q_req[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ptt_timer dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && irq_valid && irq_ready) begin
    if (q_vec.size() == 0) chk("R5 R7 R8 unexpected irq", {24'd0, irq_vector}, 32'hFFFF_FFFF);
    else begin
      int ec; logic [7:0] ev; string r;
      ec = q_cyc.pop_front(); ev = q_vec.pop_front(); r = q_req.pop_front();
      chk(r, {24'd0, irq_vector}, {24'd0, ev});
      if (ec >= 0) chk(r, cyc, ec);
    end
  end

  task automatic expect_irq(input int c, input logic [7:0] v, input string r);
    q_cyc.push_back(c); q_vec.push_back(v); q_req.push_back(r);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output int e);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; e = cyc + 1;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output int e);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a; e = cyc + 1;
    @(posedge clk); #1;
    bus_sel = 0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic drain(input int max, input string r);
    for (int i = 0; i < max && q_vec.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(r, q_vec.size(), 0);
  endtask

  function automatic logic [31:0] dsel(input logic [2:0] c);
    return {28'd0, c[2], 1'b0, c[1], c[0]};
  endfunction

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e, d; logic [31:0] v;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    // R1 reset state
    rd(12'h320, v, e); chk("R1 ctl", v, 32'h0001_0000);
    rd(12'h380, v, e); chk("R1 reload", v, 0);
    rd(12'h390, v, e); chk("R1 live", v, 0);
    rd(12'h3E0, v, e); chk("R1 div", v, 0);
    chk("R1 irq_valid", irq_valid, 0);
    // R5 one-shot, divide by 1 (code 7, R3)
    wr(12'h320, 32'h0000_0041, e);
    wr(12'h3E0, dsel(3'd7), e);
    wr(12'h380, 5, e); expect_irq(e + 5, 8'h41, "R5 R3 div1 oneshot");
    drain(40, "R5 single irq");
    rd(12'h390, v, e); chk("R5 live stays 0", v, 0);
    // R3 divide by 8, by 32, by 128
    wr(12'h3E0, dsel(3'd2), e);
    wr(12'h380, 3, e); expect_irq(e + 24, 8'h41, "R3 R4 div8");
    drain(60, "R3 div8 drained");
    wr(12'h3E0, dsel(3'd4), e);
    wr(12'h380, 2, e); expect_irq(e + 64, 8'h41, "R3 R4 div32");
    drain(100, "R3 div32 drained");
    wr(12'h3E0, dsel(3'd6), e);
    wr(12'h380, 1, e); expect_irq(e + 128, 8'h41, "R3 div128");
    drain(200, "R3 div128 drained");
    // R11 prescaler restart on divide write (div 4)
    wr(12'h3E0, dsel(3'd1), e);
    wr(12'h380, 2, e);
    wr(12'h3E0, dsel(3'd1), d); expect_irq(d + 8, 8'h41, "R11 restart");
    drain(40, "R11 drained");
    // R6 periodic then R7 stop
    wr(12'h320, 32'h0002_0077, e);
    wr(12'h3E0, dsel(3'd7), e);
    wr(12'h380, 4, e);
    expect_irq(e + 4, 8'h77, "R6 period 1");
    expect_irq(e + 8, 8'h77, "R6 period 2");
    expect_irq(e + 12, 8'h77, "R6 period 3");
    repeat (11) @(posedge clk);
    wr(12'h380, 0, d); chk("R7 stop edge", d, e + 13);
    drain(40, "R6 drained");
    repeat (20) @(posedge clk);
    rd(12'h390, v, e); chk("R7 stopped live", v, 0);
    // R8 masked expiry: count runs, no request
    wr(12'h320, 32'h0001_0055, e);
    wr(12'h380, 3, e);
    repeat (10) @(posedge clk);
    rd(12'h390, v, e); chk("R8 live ran out", v, 0);
    chk("R8 no irq", irq_valid, 0);
    // R9 stall and busy bit
    irq_ready = 0;
    wr(12'h320, 32'h0000_009C, e);
    wr(12'h380, 2, e);
    repeat (6) @(posedge clk); #1;
    chk("R9 held valid", irq_valid, 1);
    chk("R9 vector", {24'd0, irq_vector}, 32'h9C);
    rd(12'h320, v, e); chk("R9 busy set", v, 32'h0000_109C);
    expect_irq(-1, 8'h9C, "R9 accepted vector");
    @(posedge clk); #1; irq_ready = 1;
    drain(10, "R9 drained");
    rd(12'h320, v, e); chk("R9 busy clear", v, 32'h0000_009C);
    // R2 reserved bits, R3 div readback, R10 read-only live
    wr(12'h320, 32'hFFFF_FFFF, e);
    rd(12'h320, v, e); chk("R2 ctl reserved", v, 32'h0003_00FF);
    wr(12'h3E0, 32'hFFFF_FFFF, e);
    rd(12'h3E0, v, e); chk("R3 div reserved", v, 32'h0000_000B);
    wr(12'h390, 32'h1234, e);
    rd(12'h390, v, e); chk("R10 live ignores write", v, 0);
    rd(12'h3F0, v, e); chk("R2 unmapped", v, 0);
    // R10 live readback mid-count (div 2)
    wr(12'h320, 32'h0000_0021, e);
    wr(12'h3E0, dsel(3'd0), e);
    wr(12'h380, 100, e);
    repeat (6) @(posedge clk);
    rd(12'h390, v, d); chk("R10 live progress", v, 100 - (d - 1 - e) / 2);
    wr(12'h380, 0, e);
    repeat (10) @(posedge clk);
    chk("R7 final queue", q_vec.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule